// File: doc/BRIEF.md
# Decoded Tone Host Interface

This block sits between a tone classifier and a host processor. Each time the classifier finishes a decode it raises a one-cycle strobe with a 4-bit code. The block stores that code and drives it onto the host data bus. For every real tone it also sends a data-change pulse, timed to 1.0 ms at the nominal 560 kHz clock. The reserved no-tone code only refreshes the bus: it gives no pulse and no interrupt.

The host can hold the block with an active-low hold input. The first tone that arrives while hold is asserted freezes the bus on its code and holds data-change high until hold is released. Codes that arrive during the freeze are parked. When hold is released, data-change goes low. If the parked code differs from the frozen one, it is then put on the bus with a fresh pulse.

A chip-select input gates the output enables of the data bus and data-change. High-impedance is modelled by driving those enables low. When a tone is detected while the chip is deselected, the active-low interrupt output is latched low. Selecting the chip releases it high again, so several such outputs can share one wire-OR line. All inputs are taken as synchronous to `clk_i`.

Top module: `tone_host_if`

## Requirements
- R1: After reset, data_o reads the no-tone code 4'hF, chg_o is 0 and irq_no_o is 1.
- R2: A strobe with a code other than 4'hF, while hold_ni is high and nothing is frozen, puts the code on data_o one cycle later. chg_o is then high for exactly PULSE_CYC (default 560) consecutive cycles.
- R3: A new tone strobe during a running pulse updates data_o and restarts the pulse, so chg_o stays high PULSE_CYC cycles counted from the newer strobe.
- R4: A strobe carrying 4'hF updates data_o but starts no pulse and never sets the interrupt.
- R5: A tone strobe while hold_ni is low puts its code on data_o and holds chg_o high, with no time limit, for as long as hold_ni stays low.
- R6: While frozen under hold, later strobes do not change data_o.
- R7: Releasing hold_ni clears chg_o on the next cycle. If a parked code differs from data_o, it is presented instead, with a fresh PULSE_CYC pulse (no pulse if it is 4'hF).
- R8: data_oe_o and chg_oe_o equal cs_i (1 = selected, outputs driven; 0 = high-impedance).
- R9: A tone strobe (code not 4'hF) while cs_i is 0 drives irq_no_o low on the next cycle. It stays low while cs_i remains 0.
- R10: With cs_i high, irq_no_o is 1 from the next cycle on, and tone strobes do not pull it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, nominally 560 kHz |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_vld_i | input | 1 | One-cycle new-code strobe from the classifier |
| code_i | input | 4 | Decoded tone code (4'hF = no tone) |
| hold_ni | input | 1 | Host hold request, active low |
| cs_i | input | 1 | Chip select, 1 = selected |
| data_o | output | 4 | Presented tone code |
| data_oe_o | output | 1 | Output enable for data_o |
| chg_o | output | 1 | Data-change strobe / latched level under hold |
| chg_oe_o | output | 1 | Output enable for chg_o |
| irq_no_o | output | 1 | Wire-OR interrupt, active low |

## Verification
The bench targets the edges of the pulse timer:
- A restart during a running pulse. A design that only extends the pulse from its old start would drop chg_o too early.
- A no-tone strobe while a pulse is running. A design that treats 4'hF as a tone would restart the pulse or raise the interrupt.

Hold is exercised around release:
- Release with a differing parked code must re-present it with a new pulse.
- Release with nothing parked must simply clear chg_o.
- A design that freezes on any strobe, or lets parked codes leak onto the bus, disagrees with the reference model.

Random toggling of chip select checks that the interrupt is set only while deselected and that selection clears it within one cycle.

// File: rtl/tdi_pkg.sv
package tdi_pkg;
  localparam int unsigned CODE_W = 4;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t NOTONE_DEF = '1;
endpackage

// File: rtl/tdi_pulse_timer.sv
module tdi_pulse_timer #(
  parameter int unsigned PULSE_CYC = 560
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic clr_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)              cnt_d = '0;
    else if (start_i)       cnt_d = LOAD;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !clr_i) |=> busy_o); // R2
  AST_CLR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !busy_o); // R5
endmodule

// File: rtl/tdi_hold_ctrl.sv
module tdi_hold_ctrl
  import tdi_pkg::*;
#(
  parameter code_t NOTONE = NOTONE_DEF
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  code_vld_i,
  input  code_t code_i,
  input  logic  hold_ni,
  output code_t data_o,
  output logic  frozen_o,
  output logic  start_o,
  output logic  clr_o
);
  code_t data_q, data_d, pend_q, pend_d;
  logic  frz_q, frz_d, pv_q, pv_d;
  logic  tone_in, pend_new;

  assign tone_in  = code_vld_i && (code_i != NOTONE);
  assign pend_new = pv_q && (pend_q != data_q);

  always_comb begin
    data_d  = data_q;
    pend_d  = pend_q;
    frz_d   = frz_q;
    pv_d    = pv_q;
    start_o = 1'b0;
    clr_o   = 1'b0;
    if (frz_q) begin
      if (hold_ni) begin
        frz_d = 1'b0;
        pv_d  = 1'b0;
        if (code_vld_i) begin
          data_d  = code_i;
          start_o = tone_in;
        end else if (pend_new) begin
          data_d  = pend_q;
          start_o = (pend_q != NOTONE);
        end
      end else if (code_vld_i) begin
        pend_d = code_i;
        pv_d   = 1'b1;
      end
    end else if (code_vld_i) begin
      data_d = code_i;
      if (tone_in) begin
        if (!hold_ni) begin
          frz_d = 1'b1;
          clr_o = 1'b1;
        end else begin
          start_o = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= NOTONE;
      pend_q <= NOTONE;
      frz_q  <= 1'b0;
      pv_q   <= 1'b0;
    end else begin
      data_q <= data_d;
      pend_q <= pend_d;
      frz_q  <= frz_d;
      pv_q   <= pv_d;
    end
  end

  assign data_o   = data_q;
  assign frozen_o = frz_q;

  AST_FROZEN_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz_q && !hold_ni) |=> $stable(data_q)); // R6
  AST_FROZEN_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz_q && !hold_ni) |=> frz_q); // R5
  AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz_q && hold_ni) |=> !frz_q); // R7
endmodule

// File: rtl/tdi_irq_latch.sv
module tdi_irq_latch
  import tdi_pkg::*;
#(
  parameter code_t NOTONE = NOTONE_DEF
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cs_i,
  input  logic  code_vld_i,
  input  code_t code_i,
  output logic  irq_no_o
);
  logic irq_q;
  logic tone_in;

  assign tone_in = code_vld_i && (code_i != NOTONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      irq_q <= 1'b0;
    else if (cs_i)    irq_q <= 1'b0;
    else if (tone_in) irq_q <= 1'b1;
  end

  assign irq_no_o = ~irq_q;

  AST_IRQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_i && tone_in) |=> !irq_no_o); // R9
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_i && !irq_no_o) |=> !irq_no_o); // R9
  AST_IRQ_SEL_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_i |=> irq_no_o); // R10
  AST_NOTONE_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_no_o && !tone_in) |=> irq_no_o); // R4
endmodule

// File: rtl/tone_host_if.sv
module tone_host_if
  import tdi_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 560,
  parameter code_t       NOTONE    = NOTONE_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              code_vld_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              hold_ni,
  input  logic              cs_i,
  output logic [CODE_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              chg_o,
  output logic              chg_oe_o,
  output logic              irq_no_o
);
  logic frozen, start, clr, busy;

  tdi_hold_ctrl #(.NOTONE(NOTONE)) i_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .code_vld_i (code_vld_i),
    .code_i     (code_i),
    .hold_ni    (hold_ni),
    .data_o     (data_o),
    .frozen_o   (frozen),
    .start_o    (start),
    .clr_o      (clr)
  );

  tdi_pulse_timer #(.PULSE_CYC(PULSE_CYC)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .clr_i   (clr),
    .busy_o  (busy)
  );

  tdi_irq_latch #(.NOTONE(NOTONE)) i_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_i       (cs_i),
    .code_vld_i (code_vld_i),
    .code_i     (code_i),
    .irq_no_o   (irq_no_o)
  );

  assign chg_o     = frozen | busy;
  assign data_oe_o = cs_i;
  assign chg_oe_o  = cs_i;

  AST_HOLD_CHG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_vld_i && code_i != NOTONE && !hold_ni && !frozen) |=> chg_o); // R5
  AST_NOTONE_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chg_o && !frozen && code_vld_i && code_i == NOTONE) |=> !chg_o); // R4
endmodule

// File: tb/test_tone_host_if.sv
`timescale 1ns/1ps
module test_tone_host_if;
  localparam int PULSE = 560;
  localparam logic [3:0] NT = 4'hF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vld = 1'b0, hold_n = 1'b1, cs = 1'b1;
  logic [3:0] code = NT;
  logic [3:0] data;
  logic data_oe, chg, chg_oe, irq_n;
  int vectors = 0, fails = 0;

  always #2.5 clk = ~clk;

  tone_host_if #(.PULSE_CYC(PULSE)) i_tone_host_if (
    .clk_i(clk), .rst_ni(rst_n), .code_vld_i(vld), .code_i(code),
    .hold_ni(hold_n), .cs_i(cs), .data_o(data), .data_oe_o(data_oe),
    .chg_o(chg), .chg_oe_o(chg_oe), .irq_no_o(irq_n)
  );

  // reference model built from the requirements
  logic [3:0] m_data, m_pend;
  int m_cnt;
  logic m_frz, m_pv, m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data <= NT; m_pend <= NT; m_cnt <= 0; m_frz <= 0; m_pv <= 0; m_irq <= 0;
    end else begin
      if (cs) m_irq <= 1'b0;
      else if (vld && code != NT) m_irq <= 1'b1;
      if (m_cnt > 0) m_cnt <= m_cnt - 1;
      if (m_frz) begin
        if (hold_n) begin
          m_frz <= 0; m_pv <= 0;
          if (vld) begin
            m_data <= code; if (code != NT) m_cnt <= PULSE;
          end else if (m_pv && m_pend != m_data) begin
            m_data <= m_pend; if (m_pend != NT) m_cnt <= PULSE;
          end
        end else if (vld) begin
          m_pend <= code; m_pv <= 1;
        end
      end else if (vld) begin
        m_data <= code;
        if (code != NT) begin
          if (!hold_n) begin m_frz <= 1; m_cnt <= 0; end
          else m_cnt <= PULSE;
        end
      end
    end
  end

  function automatic logic exp_chg();
    return m_frz || (m_cnt != 0);
  endfunction

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic strobe(logic [3:0] c);
    vld = 1'b1; code = c; tick(); vld = 1'b0;
  endtask

  task automatic count_chg(output int n);
    n = 0;
    while (chg && n < 3 * PULSE) begin n++; tick(); end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd1013));
    repeat (3) @(negedge clk);
    chk("R1 data", data, NT); chk("R1 chg", chg, 0); chk("R1 irq", irq_n, 1);
    rst_n = 1'b1; tick();
    chk("R1 data after release", data, NT); chk("R1 irq after release", irq_n, 1);

    // R2 basic pulse
    strobe(4'h5);
    chk("R2 data", data, 5); chk("R2 chg rise", chg, 1);
    count_chg(n); chk("R2 pulse length", n, PULSE);

    // R3 restart
    strobe(4'h3);
    repeat (99) tick();
    strobe(4'h7);
    chk("R3 data", data, 7);
    count_chg(n); chk("R3 restarted length", n, PULSE);

    // R4 no-tone strobe, deselected
    cs = 1'b0; tick();
    strobe(NT);
    chk("R4 data", data, NT); chk("R4 no pulse", chg, 0); chk("R4 no irq", irq_n, 1);
    // R8 output enables
    chk("R8 data_oe low", data_oe, 0); chk("R8 chg_oe low", chg_oe, 0);
    // R9 interrupt set
    strobe(4'h2);
    chk("R9 irq low", irq_n, 0);
    repeat (50) tick();
    chk("R9 irq sticky", irq_n, 0);
    cs = 1'b1; tick();
    chk("R10 irq released", irq_n, 1);
    chk("R8 data_oe high", data_oe, 1); chk("R8 chg_oe high", chg_oe, 1);
    strobe(4'h4);
    chk("R10 tone while selected", irq_n, 1);
    count_chg(n);

    // R5/R6/R7 hold
    hold_n = 1'b0; tick();
    strobe(4'h9);
    chk("R5 data", data, 9); chk("R5 chg", chg, 1);
    repeat (1000) tick();
    chk("R5 chg latched", chg, 1);
    strobe(4'hA);
    chk("R6 data frozen", data, 9);
    strobe(NT);
    strobe(4'hA);
    chk("R6 data frozen again", data, 9);
    hold_n = 1'b1; tick();
    chk("R7 parked code", data, 4'hA); chk("R7 fresh pulse", chg, 1);
    count_chg(n); chk("R7 fresh pulse length", n, PULSE);
    hold_n = 1'b0; tick();
    strobe(4'hB);
    repeat (5) tick();
    hold_n = 1'b1; tick();
    chk("R7 chg clears", chg, 0); chk("R7 data kept", data, 4'hB);

    // random phase against the model
    for (int i = 0; i < 40000; i++) begin
      chk("R2 data model", data, m_data);
      chk("R5 chg model", chg, exp_chg());
      chk("R9 irq model", irq_n, !m_irq);
      chk("R8 oe model", data_oe, cs);
      vld = ($urandom % 40) == 0;
      code = 4'($urandom % 16);
      if (($urandom % 400) == 0) hold_n = ~hold_n;
      if (($urandom % 300) == 0) cs = ~cs;
      tick();
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule